// File: doc/BRIEF.md
# SDRAM Power-Up and Auto Refresh Sequencer

This block runs on the memory controller side of an SDRAM interface and owns the command pins during two jobs. After reset it takes the memory through its power-up ritual. First it holds a long stretch of no-operation cycles with clock enable and the data masks high. Then it closes every bank, loads the mode register from build-time parameters, and runs a group of auto refresh cycles. A parameter decides whether the mode load or the refresh group comes first. When the last wait has run out, `ready` goes high and stays high.

From then on an interval counter produces one refresh obligation per period, which is 15.6 µs at the usual 4096 refreshes per 64 ms. Obligations collect in a pending counter. While any obligation is pending and the sequencer is idle, it raises `ref_req` to an external access arbiter. It keeps the request up until the arbiter grants it. On a grant the sequencer takes the bus. If the arbiter reports open banks it closes them and waits tRP. It then issues one auto refresh and waits tRC before it hands the bus back. Refreshes may be postponed up to a parameterised number of periods. Past that number, `ref_urgent` tells the arbiter to give refresh priority.

All waits are parameters counted in clock cycles.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: During reset and the power-up wait, `sd_cke` is 1, every `sd_dqm` bit is 1, and the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111). The first other command appears exactly T_PWRUP cycles after reset is released.
- R2: The init order is a precharge-all, encoded 0010 with address bit 10 = 1. When MRS_FIRST=1 it is followed by a mode load (0000) and then INIT_REFS auto refreshes (0001). When MRS_FIRST=0 the auto refreshes come before the mode load.
- R3: After a precharge-all the next command waits T_RP cycles. After a mode load it waits T_MRD cycles, and after an auto refresh it waits T_RC cycles. Every cycle in between is a NOP.
- R4: During the mode load, address bits are set as follows, with `sd_ba` = 0:
  - bits 2..0 give the burst length (1→000, 2→001, 4→010, 8→011, full page→111);
  - bit 3 is 1 for interleaved order;
  - bits 6..4 hold the CAS latency as a binary number;
  - bit 9 is 1 for single-location writes;
  - bits 11..10 and 8..7 are 0.
- R5: `ready` rises in the cycle after the last init wait ends. That is T_RC after the last refresh when MRS_FIRST=1, or T_MRD after the mode load when MRS_FIRST=0. It then stays high until reset.
- R6: With `ready` high, one refresh obligation is added every REF_INTERVAL cycles. The first request appears REF_INTERVAL cycles after `ready` rises. `ref_req` is high only while the sequencer is idle and at least one obligation is pending. It is never high before `ready`.
- R7: Once raised, `ref_req` stays high until a cycle in which `ref_gnt` is sampled high.
- R8: When a grant is sampled with `banks_open` low, an auto refresh is issued in the next cycle. `bus_own` is high from that cycle on, and the bus is released T_RC cycles after the refresh.
- R9: When a grant is sampled with `banks_open` high, a precharge-all is issued in the next cycle. The auto refresh follows T_RP cycles later, and the bus is released T_RC after that.
- R10: The interval counter keeps running while obligations wait. The pending count saturates at MAX_POSTPONE+1, and each serviced refresh removes one obligation. `ref_urgent` is high exactly while more than MAX_POSTPONE obligations are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grants the bus for one refresh |
| banks_open | input | 1 | Arbiter reports at least one open bank |
| ready | output | 1 | Initialization complete |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_urgent | output | 1 | Postponement limit exceeded |
| bus_own | output | 1 | Sequencer currently drives the command bus |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_dqm | output | DQM_W | Data masks, held high |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address / mode word |

## Verification
The hardest state to reach is a saturated pending count. It only appears when the arbiter withholds the grant for more than MAX_POSTPONE whole refresh periods. The bench shrinks the interval and keeps the grant low until `ref_urgent` has risen and one more period has passed. It then holds the grant high to drain the count. The number of auto refresh commands that appear must equal MAX_POSTPONE+1, which exposes any lost or extra obligation. A second instance with the opposite init order and a different mode word covers the other branch of the power-up sequence.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_MRS,
    CMD_AREF
  } sd_cmd_t;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_PALL,
    ST_PALL_W,
    ST_MRS,
    ST_MRS_W,
    ST_AREF,
    ST_AREF_W,
    ST_IDLE,
    ST_SPRE,
    ST_SPRE_W,
    ST_SREF,
    ST_SREF_W
  } seq_st_t;

  function automatic int cnt_bits(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // burst length in beats -> 3-bit code; 0 selects a whole row
  function automatic logic [2:0] bl_code(input int bl);
    case (bl)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [11:0] mode_word(input int bl, input int interleave,
                                            input int cl, input int wsingle);
    logic [11:0] w;
    w      = '0;
    w[2:0] = bl_code(bl);
    w[3]   = (interleave != 0);
    w[6:4] = 3'(cl);
    w[9]   = (wsingle != 0);
    return w;
  endfunction

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(input sd_cmd_t c);
    case (c)
      CMD_PALL: return 4'b0010;
      CMD_MRS:  return 4'b0000;
      CMD_AREF: return 4'b0001;
      default:  return 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sdr_ref_sched.sv
module sdr_ref_sched #(
  parameter int REF_INTERVAL = 3900,
  parameter int MAX_POSTPONE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic ref_done,
  output logic pend_nz,
  output logic urgent
);
  import sdr_seq_pkg::*;

  localparam int IW       = cnt_bits(REF_INTERVAL);
  localparam int PEND_MAX = MAX_POSTPONE + 1;
  localparam int PW       = cnt_bits(PEND_MAX);

  logic [IW-1:0] ivl;
  logic [PW-1:0] pend;
  logic          tick;

  assign tick = ready && (ivl == IW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !ready) ivl <= '0;
    else if (tick)        ivl <= '0;
    else                  ivl <= ivl + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else begin
      case ({tick, ref_done})
        2'b10:   if (pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: ;
      endcase
    end
  end

  assign pend_nz = (pend != '0);
  assign urgent  = (pend > PW'(MAX_POSTPONE));

  AST_PEND_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX));                                          // R10
  AST_DONE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> pend_nz);                                           // R10
  AST_NO_PEND_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !pend_nz);                                            // R6
endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm #(
  parameter int T_PWRUP   = 50000,
  parameter int T_RP      = 5,
  parameter int T_RC      = 18,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 8,
  parameter int MRS_FIRST = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref_gnt,
  input  logic                   banks_open,
  input  logic                   pend_nz,
  output sdr_seq_pkg::sd_cmd_t   cmd,
  output logic                   ref_done,
  output logic                   ready,
  output logic                   ref_req,
  output logic                   bus_own
);
  import sdr_seq_pkg::*;

  localparam int TW   = cnt_bits(max2(max2(T_PWRUP, T_RC), max2(T_RP, T_MRD)));
  localparam int RW   = cnt_bits(INIT_REFS);
  localparam int GMAX = max2(max2(T_RC, T_RP), T_MRD) + 1;
  localparam int GW   = cnt_bits(GMAX);
  localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 2);
  localparam logic [TW-1:0] LD_RC  = TW'(T_RC - 2);
  localparam logic [TW-1:0] LD_MRD = TW'(T_MRD - 2);

  seq_st_t       st, st_n;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic [RW-1:0] nref;
  logic          ready_q;

  sdr_wait_timer #(.W(TW), .RST_VAL(T_PWRUP - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cmd      = CMD_NOP;
    ref_done = 1'b0;
    case (st)
      ST_PWR:    if (tmr_done) st_n = ST_PALL;
      ST_PALL:   begin cmd = CMD_PALL; tmr_load = 1'b1; tmr_val = LD_RP; st_n = ST_PALL_W; end
      ST_PALL_W: if (tmr_done) st_n = (MRS_FIRST != 0) ? ST_MRS : ST_AREF;
      ST_MRS:    begin cmd = CMD_MRS; tmr_load = 1'b1; tmr_val = LD_MRD; st_n = ST_MRS_W; end
      ST_MRS_W:  if (tmr_done) st_n = (MRS_FIRST != 0) ? ST_AREF : ST_IDLE;
      ST_AREF:   begin cmd = CMD_AREF; tmr_load = 1'b1; tmr_val = LD_RC; st_n = ST_AREF_W; end
      ST_AREF_W: if (tmr_done) begin
                   if (nref == RW'(INIT_REFS)) st_n = (MRS_FIRST != 0) ? ST_IDLE : ST_MRS;
                   else                        st_n = ST_AREF;
                 end
      ST_IDLE:   if (pend_nz && ref_gnt) st_n = banks_open ? ST_SPRE : ST_SREF;
      ST_SPRE:   begin cmd = CMD_PALL; tmr_load = 1'b1; tmr_val = LD_RP; st_n = ST_SPRE_W; end
      ST_SPRE_W: if (tmr_done) st_n = ST_SREF;
      ST_SREF:   begin
                   cmd = CMD_AREF; tmr_load = 1'b1; tmr_val = LD_RC;
                   ref_done = 1'b1; st_n = ST_SREF_W;
                 end
      ST_SREF_W: if (tmr_done) st_n = ST_IDLE;
      default:   st_n = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_PWR;
      nref    <= '0;
      ready_q <= 1'b0;
    end else begin
      st <= st_n;
      if (st == ST_AREF) nref <= nref + 1'b1;
      if (st_n == ST_IDLE) ready_q <= 1'b1;
    end
  end

  assign ready   = ready_q;
  assign ref_req = (st == ST_IDLE) && pend_nz;
  assign bus_own = (st != ST_IDLE);

  // spacing monitor: cycles since the previous non-NOP command
  sd_cmd_t       prev_cmd;
  logic [GW-1:0] gap;
  logic          cmd_issue;
  assign cmd_issue = (cmd != CMD_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cmd <= CMD_NOP;
      gap      <= GW'(GMAX);
    end else if (cmd_issue) begin
      prev_cmd <= cmd;
      gap      <= GW'(1);
    end else if (gap != GW'(GMAX)) begin
      gap <= gap + 1'b1;
    end
  end

  AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && prev_cmd == CMD_AREF) |-> gap >= GW'(T_RC));        // R3
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && prev_cmd == CMD_PALL) |-> gap >= GW'(T_RP));        // R9
  AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && prev_cmd == CMD_MRS) |-> gap >= GW'(T_MRD));        // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);                               // R7
  AST_GNT_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (bus_own && !ref_req));                  // R8
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);                                                 // R5
  AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !ref_req);                                             // R6
endmodule

// File: rtl/sdr_cmd_encoder.sv
module sdr_cmd_encoder #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  sdr_seq_pkg::sd_cmd_t cmd,
  input  logic [11:0]          mode,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [ADDR_W-1:0]    addr,
  output logic [BA_W-1:0]      ba
);
  import sdr_seq_pkg::*;

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = cmd_pins(cmd);
    addr = '0;
    ba   = '0;
    case (cmd)
      CMD_PALL: addr[10]   = 1'b1;
      CMD_MRS:  addr[11:0] = mode;
      default:  ;
    endcase
  end
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq #(
  parameter int ADDR_W           = 12,
  parameter int BA_W             = 2,
  parameter int DQM_W            = 2,
  parameter int T_PWRUP          = 50000,
  parameter int T_RP             = 5,
  parameter int T_RC             = 18,
  parameter int T_MRD            = 2,
  parameter int REF_INTERVAL     = 3900,
  parameter int INIT_REFS        = 8,
  parameter int MAX_POSTPONE     = 8,
  parameter int MRS_FIRST        = 1,
  parameter int BURST_LEN        = 8,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT          = 3,
  parameter int WRITE_SINGLE     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  input  logic              banks_open,
  output logic              ready,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              bus_own,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  import sdr_seq_pkg::*;

  localparam logic [11:0] MODE = mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_LAT, WRITE_SINGLE);

  sd_cmd_t cmd;
  logic    ref_done, pend_nz;

  sdr_ref_sched #(.REF_INTERVAL(REF_INTERVAL), .MAX_POSTPONE(MAX_POSTPONE)) u_sched (
    .clk(clk), .rst_n(rst_n), .ready(ready), .ref_done(ref_done),
    .pend_nz(pend_nz), .urgent(ref_urgent)
  );

  sdr_seq_fsm #(
    .T_PWRUP(T_PWRUP), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .INIT_REFS(INIT_REFS), .MRS_FIRST(MRS_FIRST)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .banks_open(banks_open),
    .pend_nz(pend_nz), .cmd(cmd), .ref_done(ref_done), .ready(ready),
    .ref_req(ref_req), .bus_own(bus_own)
  );

  sdr_cmd_encoder #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .cmd(cmd), .mode(MODE), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
    .cas_n(sd_cas_n), .we_n(sd_we_n), .addr(sd_addr), .ba(sd_ba)
  );

  assign sd_cke = 1'b1;
  assign sd_dqm = {DQM_W{1'b1}};
endmodule

// File: tb/test_sdram_init_refresh_seq.sv
`timescale 1ns/100ps
module test_sdram_init_refresh_seq;
  localparam int P_PWR = 40, P_RP = 3, P_RC = 7, P_MRD = 2;
  localparam int P_IVL = 60, P_NREF = 8, P_POST = 3;
  localparam logic [3:0] C_NOP = 4'b0111, C_PALL = 4'b0010, C_MRS = 4'b0000, C_AREF = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0, bopen = 1'b0;
  always #2 clk = ~clk;

  logic rdy_a, req_a, urg_a, own_a, cke_a, cs_a, ras_a, cas_a, we_a;
  logic [1:0] dqm_a, ba_a; logic [11:0] addr_a;
  logic rdy_b, req_b, urg_b, own_b, cke_b, cs_b, ras_b, cas_b, we_b;
  logic [1:0] dqm_b, ba_b; logic [11:0] addr_b;

  sdram_init_refresh_seq #(.T_PWRUP(P_PWR), .T_RP(P_RP), .T_RC(P_RC), .T_MRD(P_MRD),
    .REF_INTERVAL(P_IVL), .INIT_REFS(P_NREF), .MAX_POSTPONE(P_POST), .MRS_FIRST(1),
    .BURST_LEN(8), .BURST_INTERLEAVE(1), .CAS_LAT(3), .WRITE_SINGLE(1)) i_sdram_init_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .banks_open(bopen), .ready(rdy_a),
    .ref_req(req_a), .ref_urgent(urg_a), .bus_own(own_a), .sd_cke(cke_a), .sd_cs_n(cs_a),
    .sd_ras_n(ras_a), .sd_cas_n(cas_a), .sd_we_n(we_a), .sd_dqm(dqm_a), .sd_ba(ba_a),
    .sd_addr(addr_a));

  sdram_init_refresh_seq #(.T_PWRUP(P_PWR), .T_RP(P_RP), .T_RC(P_RC), .T_MRD(P_MRD),
    .REF_INTERVAL(P_IVL), .INIT_REFS(P_NREF), .MAX_POSTPONE(P_POST), .MRS_FIRST(0),
    .BURST_LEN(0), .BURST_INTERLEAVE(0), .CAS_LAT(2), .WRITE_SINGLE(0)) i_sdram_init_refresh_seq_alt (
    .clk(clk), .rst_n(rst_n), .ref_gnt(1'b0), .banks_open(1'b0), .ready(rdy_b),
    .ref_req(req_b), .ref_urgent(urg_b), .bus_own(own_b), .sd_cke(cke_b), .sd_cs_n(cs_b),
    .sd_ras_n(ras_b), .sd_cas_n(cas_b), .sd_we_n(we_b), .sd_dqm(dqm_b), .sd_ba(ba_b),
    .sd_addr(addr_b));

  int total = 0, bad = 0, cyc = 0, cke_bad = 0;
  int la_n = 0, lb_n = 0;
  logic [3:0] la_pins [64]; int la_cyc [64]; logic [11:0] la_addr [64]; logic [1:0] la_ba [64];
  logic [3:0] lb_pins [64]; int lb_cyc [64]; logic [11:0] lb_addr [64];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({cs_a, ras_a, cas_a, we_a} != C_NOP && la_n < 64) begin
        la_pins[la_n] = {cs_a, ras_a, cas_a, we_a}; la_cyc[la_n] = cyc;
        la_addr[la_n] = addr_a; la_ba[la_n] = ba_a; la_n++;
      end
      if ({cs_b, ras_b, cas_b, we_b} != C_NOP && lb_n < 64) begin
        lb_pins[lb_n] = {cs_b, ras_b, cas_b, we_b}; lb_cyc[lb_n] = cyc;
        lb_addr[lb_n] = addr_b; lb_n++;
      end
      if ((!rdy_a && (cke_a !== 1'b1 || dqm_a !== 2'b11)) ||
          (!rdy_b && (cke_b !== 1'b1 || dqm_b !== 2'b11))) cke_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #0.5;
  endtask

  task automatic t_reset();
    repeat (3) begin
      step();
      chk(cke_a === 1'b1 && dqm_a === 2'b11 && {cs_a, ras_a, cas_a, we_a} === C_NOP,
          "R1 reset pins", {cs_a, ras_a, cas_a, we_a}, C_NOP);
      chk(rdy_a === 1'b0 && req_a === 1'b0 && urg_a === 1'b0, "R6 reset flags", rdy_a, 0);
    end
    rst_n = 1'b1;
  endtask

  int ra;

  task automatic t_init_a();
    logic [11:0] w;
    w = '0; w[2:0] = 3'b011; w[3] = 1'b1; w[6:4] = 3'd3; w[9] = 1'b1;
    while (rdy_a !== 1'b1) step();
    ra = cyc;
    chk(la_n == 2 + P_NREF, "R2 init command count", la_n, 2 + P_NREF);
    chk(la_cyc[0] == P_PWR, "R1 power-up wait", la_cyc[0], P_PWR);
    chk(la_pins[0] === C_PALL && la_addr[0][10] === 1'b1, "R2 precharge-all first", la_pins[0], C_PALL);
    chk(la_pins[1] === C_MRS, "R2 mode load second", la_pins[1], C_MRS);
    chk(la_cyc[1] - la_cyc[0] == P_RP, "R3 tRP spacing", la_cyc[1] - la_cyc[0], P_RP);
    chk(la_addr[1] === w && la_ba[1] === 2'b00, "R4 mode word", la_addr[1], w);
    for (int k = 2; k < 2 + P_NREF; k++) begin
      chk(la_pins[k] === C_AREF, "R2 init refresh", la_pins[k], C_AREF);
      chk(la_cyc[k] - la_cyc[k-1] == ((k == 2) ? P_MRD : P_RC), "R3 spacing",
          la_cyc[k] - la_cyc[k-1], (k == 2) ? P_MRD : P_RC);
    end
    chk(ra - la_cyc[1 + P_NREF] == P_RC, "R5 ready timing", ra - la_cyc[1 + P_NREF], P_RC);
    chk(cke_bad == 0, "R1 cke/dqm high during init", cke_bad, 0);
  endtask

  task automatic t_init_b();
    logic [11:0] w;
    int rb;
    w = '0; w[2:0] = 3'b111; w[6:4] = 3'd2;
    while (rdy_b !== 1'b1) step();
    rb = cyc;
    chk(lb_n == 2 + P_NREF, "R2 alt command count", lb_n, 2 + P_NREF);
    chk(lb_pins[0] === C_PALL && lb_cyc[0] == P_PWR, "R1 alt first command", lb_cyc[0], P_PWR);
    for (int k = 1; k <= P_NREF; k++) begin
      chk(lb_pins[k] === C_AREF, "R2 alt refresh before mode load", lb_pins[k], C_AREF);
      chk(lb_cyc[k] - lb_cyc[k-1] == ((k == 1) ? P_RP : P_RC), "R3 alt spacing",
          lb_cyc[k] - lb_cyc[k-1], (k == 1) ? P_RP : P_RC);
    end
    chk(lb_pins[1 + P_NREF] === C_MRS, "R2 alt mode load last", lb_pins[1 + P_NREF], C_MRS);
    chk(lb_cyc[1 + P_NREF] - lb_cyc[P_NREF] == P_RC, "R3 alt tRC before mode load",
        lb_cyc[1 + P_NREF] - lb_cyc[P_NREF], P_RC);
    chk(lb_addr[1 + P_NREF] === w, "R4 alt mode word full page CL2", lb_addr[1 + P_NREF], w);
    chk(rb - lb_cyc[1 + P_NREF] == P_MRD, "R5 alt ready after tMRD", rb - lb_cyc[1 + P_NREF], P_MRD);
  endtask

  task automatic t_grant_closed();
    int n0, k, held;
    while (req_a !== 1'b1) step();
    chk(cyc == ra + P_IVL, "R6 first request", cyc, ra + P_IVL);
    chk(rdy_a === 1'b1, "R5 ready stays high", rdy_a, 1);
    held = 0;
    repeat (5) begin step(); if (req_a === 1'b1) held++; end
    chk(held == 5, "R7 request held without grant", held, 5);
    n0 = la_n; gnt = 1'b1;
    step(); gnt = 1'b0;
    chk(la_n == n0 + 1 && la_pins[n0] === C_AREF && la_cyc[n0] == cyc, "R8 refresh after grant",
        la_n - n0, 1);
    chk(own_a === 1'b1 && req_a === 1'b0, "R8 bus taken", own_a, 1);
    k = 0;
    while (own_a === 1'b1) begin step(); k++; end
    chk(k == P_RC, "R8 release after tRC", k, P_RC);
  endtask

  task automatic t_grant_open();
    int n0, k;
    while (req_a !== 1'b1) step();
    chk(cyc == ra + 2 * P_IVL, "R10 interval unaffected by service", cyc, ra + 2 * P_IVL);
    n0 = la_n; bopen = 1'b1; gnt = 1'b1;
    step(); gnt = 1'b0; bopen = 1'b0;
    k = 0;
    while (own_a === 1'b1) begin step(); k++; end
    chk(la_n == n0 + 2, "R9 two commands", la_n - n0, 2);
    chk(la_pins[n0] === C_PALL && la_addr[n0][10] === 1'b1, "R9 precharge-all first", la_pins[n0], C_PALL);
    chk(la_pins[n0+1] === C_AREF && la_cyc[n0+1] - la_cyc[n0] == P_RP, "R9 refresh after tRP",
        la_cyc[n0+1] - la_cyc[n0], P_RP);
    chk(k == P_RP + P_RC, "R9 release time", k, P_RP + P_RC);
  endtask

  task automatic t_postpone();
    int t1, n0;
    while (req_a !== 1'b1) step();
    t1 = cyc;
    chk(t1 == ra + 3 * P_IVL, "R6 third request", t1, ra + 3 * P_IVL);
    while (cyc < t1 + P_POST * P_IVL - 1) step();
    chk(urg_a === 1'b0, "R10 not urgent at limit", urg_a, 0);
    step();
    chk(urg_a === 1'b1, "R10 urgent past limit", urg_a, 1);
    while (cyc < t1 + (P_POST + 1) * P_IVL + 1) step();
    chk(urg_a === 1'b1 && req_a === 1'b1, "R10 still urgent after saturation", urg_a, 1);
    n0 = la_n; gnt = 1'b1;
    repeat (50) step();
    gnt = 1'b0;
    chk(la_n - n0 == P_POST + 1, "R10 saturated count drained", la_n - n0, P_POST + 1);
    chk(req_a === 1'b0 && urg_a === 1'b0, "R10 drained flags", req_a, 0);
    while (req_a !== 1'b1) step();
    chk(cyc == t1 + (P_POST + 2) * P_IVL, "R10 interval kept running", cyc, t1 + (P_POST + 2) * P_IVL);
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_init_a();
    t_init_b();
    t_grant_closed();
    t_grant_open();
    t_postpone();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule